// File: doc/BRIEF.md
# Interrupt Arbiter and Vector Selector

This block sits beside a CPU core and, at every instruction boundary, decides whether the core has to enter a hardware interrupt sequence and which vector word it must fetch. It keeps one active bit for each of three sources: a timer, a first external request (IRQ1) and a video request (IRQ2). It also keeps a disable mask that software loads. Set and clear strobes for each source let the timer or video logic raise a request and let a write to an acknowledge register drop it.

The two kinds of source are judged at different times. IRQ1 and IRQ2 are judged from a pending copy that was captured in the cycle before the boundary. The timer is judged live, after the strobes of the boundary cycle have been applied, and it is gated by the interrupt-disable flag as it stood in the previous cycle. So an acknowledge on the last cycle of an instruction cancels a timer interrupt, but a video interrupt that was still active one cycle earlier is taken anyway. A software break request overrides everything and uses the IRQ2 vector.

When an interrupt is taken, the block pulses a take signal together with three flag commands in the boundary cycle. It also places the vector on its output and keeps it there until the next take. Every pin is a plain control or status signal: no data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `irq_vector_arbiter`

## Requirements
- R1: Source bit 0 is the timer, bit 1 is IRQ1 and bit 2 is IRQ2. A source counts as requesting only while its active bit is 1 and its mask bit is 0. The mask loads `mask_wdata` on a cycle with `mask_we` high.
- R2: A 1 on `src_set[i]` sets active bit i and a 1 on `src_clr[i]` clears it. No other bit changes. If both strobes are high for the same bit in one cycle, the clear wins.
- R3: Each cycle, IRQ1 and IRQ2 pending bits are latched from the requesting set, or forced to 0 when `cpu_iflag` is 1. At a boundary these sources use that latched value, so a source acknowledged in the boundary cycle but requesting in the cycle before is still taken.
- R4: The timer is taken at a boundary only if `cpu_iflag` was 0 in the previous cycle and the timer is still active and unmasked after the boundary cycle's strobes. A timer acknowledge in the boundary cycle cancels it.
- R5: Among qualifying sources, the timer wins over IRQ1, and IRQ1 wins over IRQ2.
- R6: With `brk_req` high at a boundary, an interrupt is always taken with vector 0xFFF6, whatever the pending state.
- R7: The vector is 0xFFFA for the timer, 0xFFF8 for IRQ1 and 0xFFF6 for IRQ2.
- R8: `take_irq` is high only in a cycle with `instr_end` high, for that single cycle. With no qualifying source and no break, it stays low.
- R9: `clr_dec_flag`, `clr_mem_flag` and `set_iflag` are high exactly in the cycles where `take_irq` is high.
- R10: `vector` shows the new vector in the cycle of a take and holds that value until the next take.
- R11: Reset clears every active bit, the mask and the pending latch, sets the stored previous-cycle flag copy to 1, drives `vector` to 0x0000 and drives all pulse outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_set | input | 3 | Per-source request strobes (bit0 timer, bit1 IRQ1, bit2 IRQ2) |
| src_clr | input | 3 | Per-source acknowledge strobes |
| mask_we | input | 1 | Load enable for the disable mask |
| mask_wdata | input | 3 | New disable mask, 1 = source disabled |
| cpu_iflag | input | 1 | CPU interrupt-disable flag, sampled every cycle |
| instr_end | input | 1 | Last cycle of the current instruction |
| brk_req | input | 1 | Software break request at this boundary |
| take_irq | output | 1 | One-cycle pulse: start the interrupt sequence |
| vector | output | 16 | Vector address to fetch, held between takes |
| clr_dec_flag | output | 1 | Command: clear the decimal flag |
| clr_mem_flag | output | 1 | Command: clear the memory-mode flag |
| set_iflag | output | 1 | Command: set the interrupt-disable flag |

## Verification
Take, vector and the three flag commands depend combinationally on `instr_end`, `brk_req` and the boundary cycle's clear strobes, so they are due in the boundary cycle itself. Each boundary check samples them 5 ns after the falling edge at which its inputs are driven. A set strobe takes effect one edge later, and the IRQ1/IRQ2 pending latch one edge after that. Each table row therefore drives its setup cycle, spends one cycle for the pending latch to fill, and only then presents the boundary. The held vector is checked in the cycles after a take, and in boundaries that take nothing, against the last vector the bench expects.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int NUM_SRC   = 3;
  localparam int SRC_TIMER = 0;
  localparam int SRC_IRQ1  = 1;
  localparam int SRC_IRQ2  = 2;
  localparam int SEL_W     = $clog2(NUM_SRC + 2);

  typedef logic [NUM_SRC-1:0] src_vec_t;

  // Decision outcome; software break listed separately from hardware sources
  typedef enum logic [SEL_W-1:0] {
    PICK_NONE  = 3'd0,
    PICK_TIMER = 3'd1,
    PICK_IRQ1  = 3'd2,
    PICK_IRQ2  = 3'd3,
    PICK_BRK   = 3'd4
  } pick_t;
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
  import irq_arb_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t set_i,
  input  src_vec_t clr_i,
  input  logic     mask_we_i,
  input  src_vec_t mask_wdata_i,
  output src_vec_t req_now_o,
  output src_vec_t req_live_o
);
  src_vec_t act_q;
  src_vec_t act_nx;
  src_vec_t mask_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    // clear beats set on the same cycle
    assign act_nx[g] = (act_q[g] | set_i[g]) & ~clr_i[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act_q[g]  <= 1'b0;
        mask_q[g] <= 1'b0;
      end else begin
        act_q[g] <= act_nx[g];
        if (mask_we_i) mask_q[g] <= mask_wdata_i[g];
      end
    end

    assign req_now_o[g]  = act_q[g] & ~mask_q[g];
    assign req_live_o[g] = act_nx[g] & ~mask_q[g];
  end
endmodule

// File: rtl/irq_pend_sampler.sv
module irq_pend_sampler
  import irq_arb_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     iflag_i,
  input  src_vec_t req_now_i,
  output src_vec_t pend_q_o,
  output logic     iflag_prev_o
);
  src_vec_t pend_q;
  logic     iflag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      iflag_q <= 1'b1;
    end else begin
      pend_q  <= iflag_i ? '0 : req_now_i;
      iflag_q <= iflag_i;
    end
  end

  assign pend_q_o     = pend_q;
  assign iflag_prev_o = iflag_q;
endmodule

// File: rtl/irq_vec_select.sv
module irq_vec_select
  import irq_arb_pkg::*;
#(
  parameter int                VEC_W     = 16,
  parameter logic [VEC_W-1:0]  TIMER_VEC = 16'hFFFA,
  parameter logic [VEC_W-1:0]  IRQ1_VEC  = 16'hFFF8,
  parameter logic [VEC_W-1:0]  IRQ2_VEC  = 16'hFFF6
)(
  input  logic             instr_end_i,
  input  logic             brk_i,
  input  logic             iflag_prev_i,
  input  src_vec_t         req_live_i,
  input  src_vec_t         pend_i,
  output logic             take_o,
  output logic [VEC_W-1:0] vec_o,
  output pick_t            pick_o
);
  logic  timer_ok;
  pick_t hw_pick;
  pick_t pick;

  assign timer_ok = ~iflag_prev_i & req_live_i[SRC_TIMER];

  // Latched sources: scan downward so the lowest index is assigned last
  always_comb begin
    hw_pick = PICK_NONE;
    for (int k = NUM_SRC - 1; k > SRC_TIMER; k--) begin
      if (pend_i[k]) hw_pick = (k == SRC_IRQ1) ? PICK_IRQ1 : PICK_IRQ2;
    end
    if (timer_ok) hw_pick = PICK_TIMER;
  end

  always_comb begin
    pick = PICK_NONE;
    if (instr_end_i) pick = brk_i ? PICK_BRK : hw_pick;
  end

  always_comb begin
    unique case (pick)
      PICK_TIMER: vec_o = TIMER_VEC;
      PICK_IRQ1:  vec_o = IRQ1_VEC;
      PICK_IRQ2,
      PICK_BRK:   vec_o = IRQ2_VEC;
      default:    vec_o = '0;
    endcase
  end

  assign take_o = (pick != PICK_NONE);
  assign pick_o = pick;
endmodule

// File: rtl/irq_vector_arbiter.sv
module irq_vector_arbiter
  import irq_arb_pkg::*;
#(
  parameter int               VEC_W     = 16,
  parameter logic [VEC_W-1:0] TIMER_VEC = 16'hFFFA,
  parameter logic [VEC_W-1:0] IRQ1_VEC  = 16'hFFF8,
  parameter logic [VEC_W-1:0] IRQ2_VEC  = 16'hFFF6
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       src_set,
  input  logic [2:0]       src_clr,
  input  logic             mask_we,
  input  logic [2:0]       mask_wdata,
  input  logic             cpu_iflag,
  input  logic             instr_end,
  input  logic             brk_req,
  output logic             take_irq,
  output logic [VEC_W-1:0] vector,
  output logic             clr_dec_flag,
  output logic             clr_mem_flag,
  output logic             set_iflag
);
  src_vec_t         req_now;
  src_vec_t         req_live;
  src_vec_t         pend;
  logic             iflag_prev;
  logic             take;
  logic [VEC_W-1:0] sel_vec;
  logic [VEC_W-1:0] vec_q;
  pick_t            pick;

  irq_src_bank u_bank (
    .clk          (clk),
    .rst_n        (rst_n),
    .set_i        (src_set),
    .clr_i        (src_clr),
    .mask_we_i    (mask_we),
    .mask_wdata_i (mask_wdata),
    .req_now_o    (req_now),
    .req_live_o   (req_live)
  );

  irq_pend_sampler u_pend (
    .clk          (clk),
    .rst_n        (rst_n),
    .iflag_i      (cpu_iflag),
    .req_now_i    (req_now),
    .pend_q_o     (pend),
    .iflag_prev_o (iflag_prev)
  );

  irq_vec_select #(
    .VEC_W     (VEC_W),
    .TIMER_VEC (TIMER_VEC),
    .IRQ1_VEC  (IRQ1_VEC),
    .IRQ2_VEC  (IRQ2_VEC)
  ) u_sel (
    .instr_end_i  (instr_end),
    .brk_i        (brk_req),
    .iflag_prev_i (iflag_prev),
    .req_live_i   (req_live),
    .pend_i       (pend),
    .take_o       (take),
    .vec_o        (sel_vec),
    .pick_o       (pick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    vec_q <= '0;
    else if (take) vec_q <= sel_vec;
  end

  assign vector       = take ? sel_vec : vec_q;
  assign take_irq     = take;
  assign clr_dec_flag = take;
  assign clr_mem_flag = take;
  assign set_iflag    = take;

  logic unused_ok;
  assign unused_ok = ^pick;
endmodule

// File: rtl/irq_arb_checker.sv
module irq_arb_checker #(
  parameter int               VEC_W     = 16,
  parameter logic [VEC_W-1:0] TIMER_VEC = 16'hFFFA,
  parameter logic [VEC_W-1:0] IRQ2_VEC  = 16'hFFF6
)(
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       src_clr,
  input logic             cpu_iflag,
  input logic             instr_end,
  input logic             brk_req,
  input logic             take_irq,
  input logic [VEC_W-1:0] vector,
  input logic             clr_dec_flag,
  input logic             clr_mem_flag,
  input logic             set_iflag
);
  assert_take_at_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> instr_end);

  assert_flags_with_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq == (clr_dec_flag && clr_mem_flag && set_iflag) &&
    (clr_dec_flag == set_iflag) && (clr_mem_flag == set_iflag));

  assert_brk_vec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_end && brk_req) |-> (take_irq && vector == IRQ2_VEC));

  assert_vec_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !take_irq |-> $stable(vector));

  assert_timer_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_irq && !brk_req && src_clr[0]) |-> (vector != TIMER_VEC));

  assert_iflag_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take_irq && !brk_req) |-> !$past(cpu_iflag));
endmodule

bind irq_vector_arbiter irq_arb_checker #(
  .VEC_W     (VEC_W),
  .TIMER_VEC (TIMER_VEC),
  .IRQ2_VEC  (IRQ2_VEC)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .src_clr      (src_clr),
  .cpu_iflag    (cpu_iflag),
  .instr_end    (instr_end),
  .brk_req      (brk_req),
  .take_irq     (take_irq),
  .vector       (vector),
  .clr_dec_flag (clr_dec_flag),
  .clr_mem_flag (clr_mem_flag),
  .set_iflag    (set_iflag)
);

// File: tb/tb_irq_vector_arbiter.sv
`timescale 1ns/1ps
module tb_irq_vector_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  src_set = '0, src_clr = '0, mask_wdata = '0;
  logic        mask_we = 1'b0, cpu_iflag = 1'b1, instr_end = 1'b0, brk_req = 1'b0;
  logic        take_irq, clr_dec_flag, clr_mem_flag, set_iflag;
  logic [15:0] vector;

  int n_chk = 0, n_bad = 0;
  logic [15:0] last_vec = 16'h0000;
  logic done = 1'b0;

  always #10 clk = ~clk;

  irq_vector_arbiter dut (
    .clk(clk), .rst_n(rst_n), .src_set(src_set), .src_clr(src_clr),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .cpu_iflag(cpu_iflag),
    .instr_end(instr_end), .brk_req(brk_req), .take_irq(take_irq),
    .vector(vector), .clr_dec_flag(clr_dec_flag), .clr_mem_flag(clr_mem_flag),
    .set_iflag(set_iflag)
  );

  // row: {preset[3], mask[3], iflag[1], final_clr[3], brk[1], take[1], vec[16]}
  localparam int NV = 15;
  localparam logic [27:0] TBL [NV] = '{
    {3'b001, 3'b000, 1'b0, 3'b000, 1'b0, 1'b1, 16'hFFFA}, // R7 timer
    {3'b010, 3'b000, 1'b0, 3'b000, 1'b0, 1'b1, 16'hFFF8}, // R7 irq1
    {3'b100, 3'b000, 1'b0, 3'b000, 1'b0, 1'b1, 16'hFFF6}, // R7 irq2
    {3'b111, 3'b000, 1'b0, 3'b000, 1'b0, 1'b1, 16'hFFFA}, // R5 all
    {3'b110, 3'b000, 1'b0, 3'b000, 1'b0, 1'b1, 16'hFFF8}, // R5 irq1 over irq2
    {3'b001, 3'b000, 1'b0, 3'b001, 1'b0, 1'b0, 16'h0000}, // R4 ack cancels
    {3'b100, 3'b000, 1'b0, 3'b100, 1'b0, 1'b1, 16'hFFF6}, // R3 ack late
    {3'b010, 3'b000, 1'b0, 3'b010, 1'b0, 1'b1, 16'hFFF8}, // R3 ack late
    {3'b011, 3'b000, 1'b0, 3'b001, 1'b0, 1'b1, 16'hFFF8}, // R4 falls to irq1
    {3'b111, 3'b001, 1'b0, 3'b000, 1'b0, 1'b1, 16'hFFF8}, // R1 timer masked
    {3'b111, 3'b111, 1'b0, 3'b000, 1'b0, 1'b0, 16'h0000}, // R1 all masked
    {3'b111, 3'b000, 1'b1, 3'b000, 1'b0, 1'b0, 16'h0000}, // R3 iflag
    {3'b000, 3'b000, 1'b0, 3'b000, 1'b1, 1'b1, 16'hFFF6}, // R6 break
    {3'b001, 3'b000, 1'b0, 3'b000, 1'b1, 1'b1, 16'hFFF6}, // R6 break wins
    {3'b000, 3'b000, 1'b0, 3'b000, 1'b0, 1'b0, 16'h0000}  // R8 nothing
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    src_set = '0; src_clr = '0; mask_we = 1'b0; instr_end = 1'b0; brk_req = 1'b0;
  endtask

  // boundary check, sampled 5 ns after the driving falling edge
  task automatic boundary(input string req, input logic et, input logic [15:0] ev);
    #5;
    chk(req, {31'd0, take_irq}, {31'd0, et});
    chk(req, {16'd0, vector}, {16'd0, et ? ev : last_vec});
    chk("R9", {29'd0, clr_dec_flag, clr_mem_flag, set_iflag}, {29'd0, {3{et}}});
    if (et) last_vec = ev;
  endtask

  task automatic wipe();
    @(negedge clk); idle(); src_clr = 3'b111; mask_we = 1'b1; mask_wdata = '0; cpu_iflag = 1'b1;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #5;
    chk("R11", {31'd0, take_irq}, 32'd0);
    chk("R11", {16'd0, vector}, 32'h0000);
    chk("R11", {29'd0, clr_dec_flag, clr_mem_flag, set_iflag}, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [27:0] r;
      r = TBL[i];
      @(negedge clk); idle(); src_clr = 3'b111; mask_we = 1'b1; mask_wdata = r[24:22]; cpu_iflag = 1'b1;
      @(negedge clk); idle(); src_set = r[27:25]; cpu_iflag = r[21];
      @(negedge clk); idle(); cpu_iflag = r[21];
      @(negedge clk); idle(); cpu_iflag = r[21]; src_clr = r[20:18];
      instr_end = 1'b1; brk_req = r[17];
      boundary($sformatf("R5/R7 row%0d", i), r[16], r[15:0]);
    end

    // R8: requesting source but no boundary, then boundary, then R10 hold
    wipe();
    @(negedge clk); idle(); src_set = 3'b010; cpu_iflag = 1'b0;
    @(negedge clk); idle();
    @(negedge clk); idle();
    #5 chk("R8 no boundary", {31'd0, take_irq}, 32'd0);
    @(negedge clk); idle(); instr_end = 1'b1;
    boundary("R8 boundary", 1'b1, 16'hFFF8);
    @(negedge clk); idle(); cpu_iflag = 1'b1;
    #5 chk("R8 single pulse", {31'd0, take_irq}, 32'd0);
    chk("R10 hold", {16'd0, vector}, {16'd0, 16'hFFF8});
    @(negedge clk); idle();
    #5 chk("R10 hold2", {16'd0, vector}, {16'd0, 16'hFFF8});

    // R2: set and clear together, clear wins
    wipe();
    @(negedge clk); idle(); cpu_iflag = 1'b0; src_set = 3'b001; src_clr = 3'b001;
    @(negedge clk); idle();
    @(negedge clk); idle(); instr_end = 1'b1;
    boundary("R2 clear wins", 1'b0, 16'h0000);
    // R2: clearing one bit leaves the others
    @(negedge clk); idle(); src_set = 3'b110;
    @(negedge clk); idle(); src_clr = 3'b010;
    @(negedge clk); idle();
    @(negedge clk); idle(); instr_end = 1'b1;
    boundary("R2 other bit kept", 1'b1, 16'hFFF6);

    // R4: timer waits for the previous-cycle flag copy
    wipe();
    @(negedge clk); idle(); src_set = 3'b001; cpu_iflag = 1'b1;
    @(negedge clk); idle(); cpu_iflag = 1'b0; instr_end = 1'b1;
    boundary("R4 prev flag set", 1'b0, 16'h0000);
    @(negedge clk); idle(); cpu_iflag = 1'b0; instr_end = 1'b1;
    boundary("R4 prev flag clear", 1'b1, 16'hFFFA);

    // R11: reset drops active requests
    @(negedge clk); idle(); src_set = 3'b111; cpu_iflag = 1'b0;
    @(negedge clk); idle(); rst_n = 1'b0;
    @(negedge clk); idle(); rst_n = 1'b1;
    #5 chk("R11 vector", {16'd0, vector}, 32'h0000);
    last_vec = 16'h0000;
    @(negedge clk); idle(); cpu_iflag = 1'b0;
    @(negedge clk); idle(); instr_end = 1'b1;
    boundary("R11 requests gone", 1'b0, 16'h0000);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule